// File: doc/BRIEF.md
# Closed-Caption Line Encoder

This block produces the digital luma samples of a closed-caption burst for a video encoder. A timing generator supplies the current line number, a field flag and a sample count within the line. When the line is the caption line of the current field and that field's caption enable is set, the block emits, starting at a fixed sample, a sine-shaped clock run-in, two low bits, a high start bit and sixteen data bits. The data bits come from two bytes per field. Downstream logic uses the insert-valid flag to replace the normal luma with the caption code.

Software writes four caption bytes and an enable register through a simple write port. The bytes go into a staging bank. The whole bank is copied into the live bank when the frame sync input falls. This allows the next frame's captions to be written while the current frame is on screen. The bit period is a fraction of the clock period: 1716/32 clocks, or about 53.6. An accumulator produces it, so the timing error stays below one clock across the whole burst.

The caption output is a stream paced by the video timing. It has a valid flag and no ready, because the video path cannot stall, so back-pressure is never applied. Each output sample corresponds to the sample count presented one clock earlier.

Top module: `cc_line_encoder`

## Requirements
- R1: After reset the luma output is the blanking code 240 and the valid flag is low. Both field enables are off. All four staging and live bytes hold 0x80.
- R2: A burst is only inserted on these lines: line 21 with field flag 0 and line 284 with field flag 1 when `std625` is 0; line 22 with field flag 0 and line 335 with field flag 1 when `std625` is 1. Any other combination of line and field gives blanking with valid low.
- R3: On a caption line whose field is enabled, the burst starts at sample count 284. The output for sample count s appears one clock after s is presented, and valid is high from the first burst sample.
- R4: Burst sample k belongs to bit slot floor(k*32/1716). The burst spans 26 slots, which is exactly 1395 samples with valid high; after that, valid is low and the output is blanking.
- R5: Slots 0 to 6 form the run-in. With acc = (k*32) mod 1716, ph = floor(acc*64/1716) and t = min(ph, 64-ph), the luma is 240 + floor(280*t*t*(96-2t)/32768). The run-in therefore spans 240 to 520.
- R6: Slots 7 and 8 are at blanking (240). Slot 9 is the start bit at the pulse level (520).
- R7: Slots 10 to 17 carry the field's first byte from bit 0 up to bit 7. Slots 18 to 25 carry its second byte in the same order. A 1 bit is 520 and a 0 bit is 240. Field 1 uses live bytes 0 and 1; field 2 uses live bytes 2 and 3.
- R8: A write to address 4 sets the enables: data bit 0 enables field 1 and data bit 1 enables field 2. On a caption line whose field is disabled, the luma is blanking and valid stays low.
- R9: A write to address 0 to 3 loads staging byte 0 to 3: field 1 first and second, then field 2 first and second. The burst keeps using the live bytes until the next frame-sync fall.
- R10: A falling edge of `fsync` (high in one cycle, low in the next) copies all four staging bytes into the live bytes. If a write happens in the same cycle as the fall, the live bytes get the staging contents from before that write.
- R11: While valid is low, the luma output equals the blanking code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| std625 | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| line_num | input | 10 | Current line number from the timing generator |
| field | input | 1 | Field flag: 0 = first field, 1 = second field |
| sample_cnt | input | 11 | Sample index within the line |
| fsync | input | 1 | Frame sync; its falling edge commits the staged bytes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..3 bytes, 4 enables |
| wr_data | input | 8 | Register write data |
| cc_luma | output | 10 | Caption luma code |
| cc_valid | output | 1 | High on samples where the caption code replaces luma |

## Verification
The hardest case to reach is a register write in the same clock as the frame-sync fall. That case decides whether the live bank gets the old or the new staging value. The stimulus raises `fsync` for one cycle, then drops it in the same cycle that it presents a write to byte 0. A full caption line then shows which value was committed, and a second fall shows that the write did reach staging. The fractional bit timing is covered by comparing every one of the 1395 burst samples against the slot and phase computed from the sample offset.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Slot structure of one caption burst.
  localparam int CC_RUNIN_SLOTS = 7;
  localparam int CC_GAP_SLOTS   = 2;
  localparam int CC_DATA_BITS   = 16;
  localparam int CC_START_SLOT  = CC_RUNIN_SLOTS + CC_GAP_SLOTS;
  localparam int CC_FIRST_DATA  = CC_START_SLOT + 1;
  localparam int CC_SLOTS       = CC_FIRST_DATA + CC_DATA_BITS;
  // Phase resolution of the run-in curve per bit period.
  localparam int CC_PH_STEPS    = 64;

  typedef enum logic [1:0] {
    SEG_RUNIN,
    SEG_GAP,
    SEG_START,
    SEG_DATA
  } cc_seg_e;

  function automatic cc_seg_e cc_seg_of(input int slot);
    if (slot < CC_RUNIN_SLOTS)      return SEG_RUNIN;
    else if (slot < CC_START_SLOT)  return SEG_GAP;
    else if (slot == CC_START_SLOT) return SEG_START;
    else                            return SEG_DATA;
  endfunction
endpackage

// File: rtl/cc_byte_bank.sv
module cc_byte_bank #(
  parameter int N_BYTES = 4,
  parameter int ADDR_W  = 3,
  parameter int EN_ADDR = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 fsync_i,
  output logic [8*N_BYTES-1:0] live_flat_o,
  output logic [1:0]           en_o
);
  logic fsync_q;
  logic commit;

  assign commit = fsync_q & ~fsync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsync_q <= 1'b0;
    else        fsync_q <= fsync_i;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [7:0] stage_q;
    logic [7:0] live_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= 8'h80;
        live_q  <= 8'h80;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(g)) stage_q <= wr_data;
        if (commit) live_q <= stage_q;
      end
    end
    assign live_flat_o[8*g +: 8] = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   en_o <= 2'b00;
    else if (wr_en && wr_addr == ADDR_W'(EN_ADDR)) en_o <= wr_data[1:0];
  end
endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int BIT_NUM = 1716,
  parameter int BIT_DEN = 32,
  parameter int N_SLOTS = 26,
  parameter int ACC_W   = 11,
  parameter int SLOT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              act_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W:0]    sum;
  logic              wrap;
  logic              last;

  always_comb begin
    act_o  = start_i | run_q;
    slot_o = start_i ? '0 : slot_q;
    acc_o  = start_i ? '0 : acc_q;
    sum    = {1'b0, acc_o} + (ACC_W+1)'(BIT_DEN);
    wrap   = sum >= (ACC_W+1)'(BIT_NUM);
    last   = wrap && (slot_o == SLOT_W'(N_SLOTS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      acc_q  <= '0;
    end else if (act_o) begin
      run_q  <= !last;
      slot_q <= slot_o + SLOT_W'(wrap);
      acc_q  <= wrap ? ACC_W'(sum - (ACC_W+1)'(BIT_NUM)) : sum[ACC_W-1:0];
    end else begin
      run_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_wave_gen.sv
module cc_wave_gen #(
  parameter int BIT_NUM    = 1716,
  parameter int LVL_W      = 10,
  parameter int BLANK_CODE = 240,
  parameter int HIGH_CODE  = 520,
  parameter int ACC_W      = 11,
  parameter int SLOT_W     = 5
) (
  input  logic              act_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [15:0]       data_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              vld_o
);
  import cc_pkg::*;

  localparam int AMP  = HIGH_CODE - BLANK_CODE;
  localparam int HALF = CC_PH_STEPS / 2;
  localparam int FULL = HALF * HALF * HALF;

  logic [31:0] ph;
  logic [31:0] tri_t;
  logic [31:0] bump;
  logic [31:0] curve;
  logic [3:0]  didx;
  cc_seg_e     seg;

  always_comb begin
    ph    = (32'(acc_i) * 32'(CC_PH_STEPS)) / 32'(BIT_NUM);
    tri_t = (ph < 32'(HALF)) ? ph : (32'(CC_PH_STEPS) - ph);
    bump  = tri_t * tri_t * (32'(3 * HALF) - 32'd2 * tri_t);
    curve = (32'(AMP) * bump) / 32'(FULL);
    seg   = cc_seg_of(int'(slot_i));
    didx  = 4'(slot_i - SLOT_W'(CC_FIRST_DATA));
    lvl_o = LVL_W'(BLANK_CODE);
    vld_o = act_i;
    if (act_i) begin
      unique case (seg)
        SEG_RUNIN: lvl_o = LVL_W'(32'(BLANK_CODE) + curve);
        SEG_GAP:   lvl_o = LVL_W'(BLANK_CODE);
        SEG_START: lvl_o = LVL_W'(HIGH_CODE);
        SEG_DATA:  lvl_o = data_i[didx] ? LVL_W'(HIGH_CODE) : LVL_W'(BLANK_CODE);
      endcase
    end
  end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder #(
  parameter int LINE_W       = 10,
  parameter int SAMP_W       = 11,
  parameter int LVL_W        = 10,
  parameter int BIT_NUM      = 1716,
  parameter int BIT_DEN      = 32,
  parameter int START_SAMPLE = 284,
  parameter int BLANK_CODE   = 240,
  parameter int HIGH_CODE    = 520,
  parameter int L525_F1      = 21,
  parameter int L525_F2      = 284,
  parameter int L625_F1      = 22,
  parameter int L625_F2      = 335
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std625,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic [SAMP_W-1:0] sample_cnt,
  input  logic              fsync,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [LVL_W-1:0]  cc_luma,
  output logic              cc_valid
);
  import cc_pkg::*;

  localparam int N_BYTES = 4;
  localparam int ACC_W   = $clog2(BIT_NUM + BIT_DEN);
  localparam int SLOT_W  = $clog2(CC_SLOTS + 1);

  logic [8*N_BYTES-1:0] live_flat;
  logic [1:0]           en_bits;
  logic [LINE_W-1:0]    cap_f1;
  logic [LINE_W-1:0]    cap_f2;
  logic                 line_hit;
  logic                 start;
  logic                 run_fld_q;
  logic                 use_f2;
  logic [15:0]          data_word;
  logic                 t_act;
  logic [SLOT_W-1:0]    t_slot;
  logic [ACC_W-1:0]     t_acc;
  logic [LVL_W-1:0]     w_lvl;
  logic                 w_vld;

  cc_byte_bank #(
    .N_BYTES(N_BYTES), .ADDR_W(3), .EN_ADDR(N_BYTES)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsync_i(fsync), .live_flat_o(live_flat), .en_o(en_bits)
  );

  always_comb begin
    cap_f1   = std625 ? LINE_W'(L625_F1) : LINE_W'(L525_F1);
    cap_f2   = std625 ? LINE_W'(L625_F2) : LINE_W'(L525_F2);
    line_hit = field ? (line_num == cap_f2) : (line_num == cap_f1);
    start    = line_hit && (field ? en_bits[1] : en_bits[0])
               && (sample_cnt == SAMP_W'(START_SAMPLE));
    use_f2   = start ? field : run_fld_q;
    data_word = use_f2 ? live_flat[31:16] : live_flat[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_fld_q <= 1'b0;
    else if (start) run_fld_q <= field;
  end

  cc_bit_timer #(
    .BIT_NUM(BIT_NUM), .BIT_DEN(BIT_DEN), .N_SLOTS(CC_SLOTS),
    .ACC_W(ACC_W), .SLOT_W(SLOT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .act_o(t_act), .slot_o(t_slot), .acc_o(t_acc)
  );

  cc_wave_gen #(
    .BIT_NUM(BIT_NUM), .LVL_W(LVL_W), .BLANK_CODE(BLANK_CODE),
    .HIGH_CODE(HIGH_CODE), .ACC_W(ACC_W), .SLOT_W(SLOT_W)
  ) u_wave (
    .act_i(t_act), .slot_i(t_slot), .acc_i(t_acc), .data_i(data_word),
    .lvl_o(w_lvl), .vld_o(w_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_luma  <= LVL_W'(BLANK_CODE);
      cc_valid <= 1'b0;
    end else begin
      cc_luma  <= w_lvl;
      cc_valid <= w_vld;
    end
  end
endmodule

// File: rtl/cc_line_encoder_sva.sv
module cc_line_encoder_sva #(
  parameter int LINE_W       = 10,
  parameter int SAMP_W       = 11,
  parameter int LVL_W        = 10,
  parameter int BIT_NUM      = 1716,
  parameter int BIT_DEN      = 32,
  parameter int START_SAMPLE = 284,
  parameter int BLANK_CODE   = 240,
  parameter int HIGH_CODE    = 520,
  parameter int L525_F1      = 21,
  parameter int L525_F2      = 284,
  parameter int L625_F1      = 22,
  parameter int L625_F2      = 335
) (
  input logic              clk,
  input logic              rst_n,
  input logic              std625,
  input logic [LINE_W-1:0] line_num,
  input logic              field,
  input logic [SAMP_W-1:0] sample_cnt,
  input logic              fsync,
  input logic [LVL_W-1:0]  cc_luma,
  input logic              cc_valid,
  input logic [1:0]        en_bits,
  input logic [31:0]       live_flat
);
  import cc_pkg::*;

  localparam int BURST_LEN = (CC_SLOTS * BIT_NUM + BIT_DEN - 1) / BIT_DEN;

  logic        chk_hit;
  logic        chk_en;
  logic        chk_at_start;
  logic        fs_prev;
  logic [15:0] run_len;

  always_comb begin
    if (std625)
      chk_hit = field ? (line_num == LINE_W'(L625_F2)) : (line_num == LINE_W'(L625_F1));
    else
      chk_hit = field ? (line_num == LINE_W'(L525_F2)) : (line_num == LINE_W'(L525_F1));
    chk_en       = field ? en_bits[1] : en_bits[0];
    chk_at_start = chk_hit && (sample_cnt == SAMP_W'(START_SAMPLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev <= 1'b0;
      run_len <= '0;
    end else begin
      fs_prev <= fsync;
      run_len <= cc_valid ? run_len + 16'd1 : 16'd0;
    end
  end

  assert_idle_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_valid |-> cc_luma == LVL_W'(BLANK_CODE));

  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> (cc_luma >= LVL_W'(BLANK_CODE) && cc_luma <= LVL_W'(HIGH_CODE)));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_at_start && chk_en) |=> cc_valid);

  assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_valid) |-> $past(sample_cnt) == SAMP_W'(START_SAMPLE));

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_valid) |-> run_len == 16'(BURST_LEN));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_at_start && !chk_en && !cc_valid) |=> !cc_valid);

  assert_hold_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_prev && !fsync) |=> $stable(live_flat));
endmodule

bind cc_line_encoder cc_line_encoder_sva #(
  .LINE_W(LINE_W), .SAMP_W(SAMP_W), .LVL_W(LVL_W), .BIT_NUM(BIT_NUM),
  .BIT_DEN(BIT_DEN), .START_SAMPLE(START_SAMPLE), .BLANK_CODE(BLANK_CODE),
  .HIGH_CODE(HIGH_CODE), .L525_F1(L525_F1), .L525_F2(L525_F2),
  .L625_F1(L625_F1), .L625_F2(L625_F2)
) u_sva (
  .clk(clk), .rst_n(rst_n), .std625(std625), .line_num(line_num),
  .field(field), .sample_cnt(sample_cnt), .fsync(fsync), .cc_luma(cc_luma),
  .cc_valid(cc_valid), .en_bits(en_bits), .live_flat(live_flat)
);

// File: tb/cc_line_encoder_test.sv
module cc_line_encoder_test;
  localparam int LINE_LEN = 1716;
  localparam int START    = 284;
  localparam int NUM      = 1716;
  localparam int DEN      = 32;
  localparam int BURST    = 1395;
  localparam int BLANK    = 240;
  localparam int HIGH     = 520;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       std625 = 1'b0;
  logic [9:0] line_num = '0;
  logic       field = 1'b0;
  logic [10:0] sample_cnt = '0;
  logic       fsync = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] cc_luma;
  logic       cc_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  typedef struct {
    int    luma;
    bit    vld;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // Bench model of the register state.
  logic [7:0] m_stage[4];
  logic [7:0] m_live[4];
  logic [1:0] m_en;

  always #10 clk = ~clk;

  cc_line_encoder uut (
    .clk(clk), .rst_n(rst_n), .std625(std625), .line_num(line_num),
    .field(field), .sample_cnt(sample_cnt), .fsync(fsync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cc_luma(cc_luma), .cc_valid(cc_valid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Monitor: compares each output sample with the scoreboard head.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cc_valid == e.vld, e.tag, "valid", int'(cc_valid), int'(e.vld));
        check(int'(cc_luma) == e.luma, e.tag, "luma", int'(cc_luma), e.luma);
      end
    end
  end

  function automatic exp_t burst_sample(input int k, input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    int slot, acc, ph, t;
    logic [15:0] w;
    slot = (k * DEN) / NUM;
    acc  = (k * DEN) % NUM;
    e.vld = 1'b1;
    if (slot < 7) begin
      ph = (acc * 64) / NUM;
      t  = (ph < 32) ? ph : 64 - ph;
      e.luma = BLANK + (280 * t * t * (96 - 2 * t)) / 32768;
      e.tag  = "R5";
    end else if (slot < 9) begin
      e.luma = BLANK; e.tag = "R6";
    end else if (slot == 9) begin
      e.luma = HIGH;  e.tag = "R6";
    end else begin
      w = {b, a};
      e.luma = w[slot - 10] ? HIGH : BLANK;
      e.tag  = "R7";
    end
    if (k == 0) e.tag = "R3";
    else if (k == BURST - 1) e.tag = "R4";
    return e;
  endfunction

  // Driver: presents one full line and pushes the expected output per sample.
  task automatic run_line(input int ln, input bit fld);
    int  f1, f2;
    bit  hit, en;
    f1  = std625 ? 22 : 21;
    f2  = std625 ? 335 : 284;
    hit = fld ? (ln == f2) : (ln == f1);
    en  = fld ? m_en[1] : m_en[0];
    for (int s = 0; s < LINE_LEN; s++) begin
      exp_t e;
      @(negedge clk);
      line_num   = 10'(ln);
      field      = fld;
      sample_cnt = 11'(s);
      if (hit && en && s >= START && (s - START) < BURST) begin
        e = burst_sample(s - START, fld ? m_live[2] : m_live[0], fld ? m_live[3] : m_live[1]);
      end else begin
        e.luma = BLANK;
        e.vld  = 1'b0;
        e.tag  = !hit ? "R2" : (!en ? "R8" : (s >= START ? "R4" : "R11"));
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    line_num   = '0;
    sample_cnt = '0;
  endtask

  task automatic reg_write(input int addr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 4) m_stage[addr] = d;
    else m_en = d[1:0];
  endtask

  task automatic frame_sync;
    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_stage[i] = 8'h80; m_live[i] = 8'h80; end
    m_en = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(cc_luma == 10'd240, "R1", "reset luma", int'(cc_luma), 240);
    check(cc_valid == 1'b0, "R1", "reset valid", int'(cc_valid), 0);

    // R1/R8: enables are off after reset
    run_line(21, 1'b0);
    // R1: live bytes are 0x80 after reset
    reg_write(4, 8'h03);
    run_line(21, 1'b0);

    // R9: staged writes do not reach the burst before a frame sync fall
    reg_write(0, 8'hC1);
    reg_write(1, 8'hC2);
    reg_write(2, 8'h57);
    reg_write(3, 8'h6E);
    run_line(21, 1'b0);

    // R10: commit, then R7 data for both fields, R2 field-2 line
    frame_sync();
    run_line(21, 1'b0);
    run_line(284, 1'b1);
    // R2: wrong line or wrong field flag
    run_line(22, 1'b0);
    run_line(284, 1'b0);

    // R8: field 1 disabled, field 2 still enabled
    reg_write(4, 8'h02);
    run_line(21, 1'b0);
    run_line(284, 1'b1);

    // R2: 625-line caption lines
    std625 = 1'b1;
    reg_write(4, 8'h03);
    run_line(22, 1'b0);
    run_line(335, 1'b1);
    run_line(21, 1'b0);

    // R10: write in the same cycle as the fsync fall
    @(negedge clk);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
    for (int i = 0; i < 4; i++) m_live[i] = m_stage[i];
    m_stage[0] = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    run_line(22, 1'b0);
    frame_sync();
    run_line(22, 1'b0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule